// File: doc/BRIEF.md
# Multicycle Processor Sequencer

This block is the control state machine of a small multicycle RISC core. Every instruction passes through a fetch state and a decode state. It then runs one or more execute states chosen by the opcode and function fields of the instruction register. Memory instructions add further states, and most instructions end in a write-back state before the machine returns to fetch. The datapath supplies the instruction fields, a busy flag from the memory and the result of a zero test. In return the sequencer drives register clock enables, operand and result selects, the ALU function, memory read and write requests and the register-file write strobe. It also reports its current state as a one-hot vector.

Fetch, load and store wait on the memory. A request stays asserted while the memory reports busy, and the data is captured in the first request cycle in which busy is low. The memory must raise busy in the same cycle the request appears whenever it needs more time.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is sampled high, the state is FETCH. While `rst` is high, every enable, request and select output is 0.
- R2: In FETCH, `mem_rd` is 1 in every cycle. The machine stays in FETCH while `mem_busy` is 1. `ir_ce` is 1 only in the FETCH cycle where `mem_busy` is 0, and the next state is DECODE.
- R3: DECODE lasts exactly one cycle. In it `ab_ce` and `pc_ce` are 1, with `a_sel`=PC, `b_sel`=one and `alu_fn`=add.
- R4: add (opcode 000000, function 100011) and addi (opcode 001011) go through EXEC with `alu_fn`=add and `c_ce`=1. The B operand is the register for add and the immediate for addi. add then goes to WBR and addi to WBI.
- R5: The tests seqi (opcode 011010, equal), sgri (opcode 011001, greater) and sgr (opcode 000000, function 101011, greater) run in EXEC with the matching `alu_fn`. The two I-type tests take the immediate and finish in WBI; sgr takes the B register and finishes in WBR.
- R6: The one-place shifts slli (opcode 000000, function 000000) and srli (opcode 000000, function 000010) run in EXEC with `b_sel`=one and finish in WBR.
- R7: lw (opcode 100011) runs ADDR, LOAD, MDR2C, WBI. ADDR asserts `mar_ce` with A plus the immediate. LOAD holds `mem_rd` and stays while busy, and asserts `mdr_ce` from memory in its done cycle. MDR2C asserts `c_ce` with `c_src`=MDR.
- R8: sw (opcode 101011) runs ADDR, COPYMDR, STORE. COPYMDR asserts `mdr_ce` with `mdr_src`=B. STORE holds `mem_wr` and stays while busy, then returns to FETCH.
- R9: beqz (opcode 000100) and bnez (opcode 000101) enter BRANCH, which drives A against zero with `alu_fn`=equal. beqz is taken when `test_true` is 1 and bnez when it is 0. A taken branch goes to BTAKEN, which loads PC with PC plus the immediate. A branch that is not taken goes to FETCH.
- R10: jr (opcode 010110) uses one JR state that loads PC with A plus zero, then returns to FETCH.
- R11: jalr (opcode 010111) runs SAVEPC (`c_ce`, `c_src`=PC), then WBLINK (`gpr_we`, `dst_sel`=link), then JALR (PC gets A plus zero).
- R12: Any other opcode, or opcode 000000 with any other function, goes from DECODE straight to FETCH. No register write, no C load and no memory request occurs.
- R13: `state_oh` always has exactly one bit set. Its bits are FETCH 0, DECODE 1, EXEC 2, WBR 3, WBI 4, ADDR 5, LOAD 6, MDR2C 7, COPYMDR 8, STORE 9, BRANCH 10, BTAKEN 11, JR 12, SAVEPC 13, WBLINK 14, JALR 15. `mem_rd` and `mem_wr` are never high together, and `gpr_we` is high only in WBI, WBR and WBLINK.
- R14: The select codes are as follows. `a_sel`: 0=A, 1=PC. `b_sel`: 0=B, 1=immediate, 2=zero, 3=one. `alu_fn`: 0=add, 1=equal, 2=greater, 3=shift left, 4=shift right. `c_src`: 0=ALU, 1=MDR, 2=PC. `mdr_src`: 0=memory, 1=B. `dst_sel`: 0=I-type RD field, 1=R-type RD field, 2=R31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Primary opcode field of the instruction register |
| func | input | 6 | Function field of the instruction register |
| mem_busy | input | 1 | Memory still working on the current request |
| test_true | input | 1 | Zero-test result from the datapath ALU |
| state_oh | output | 16 | One-hot current state |
| ir_ce | output | 1 | Instruction register load |
| pc_ce | output | 1 | Program counter load |
| ab_ce | output | 1 | A and B operand registers load |
| c_ce | output | 1 | C result register load |
| mar_ce | output | 1 | Memory address register load |
| mdr_ce | output | 1 | Memory data register load |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| gpr_we | output | 1 | Register-file write |
| dst_sel | output | 2 | Destination register select |
| a_sel | output | 1 | ALU first operand select |
| b_sel | output | 2 | ALU second operand select |
| alu_fn | output | 3 | ALU function |
| c_src | output | 2 | Source of the C register |
| mdr_src | output | 1 | Source of the memory data register |

## Verification
The hardest situations to reach from the ports are the wait loops in FETCH, LOAD and STORE. The BRANCH decision also depends on pairing the branch kind with the zero-test input. The bench places a memory stub with a programmable latency on the request outputs, so every instruction runs both with zero wait and with two busy cycles in each memory state. It sweeps all 64 opcodes and all 64 function codes under both values of the test input. A reset is also applied in the middle of a stalled load to show that the sequencer falls back to a quiet FETCH.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPW    = 6;
    localparam int FNW    = 6;
    localparam int NSTATE = 16;
    localparam int SW     = $clog2(NSTATE);

    typedef enum logic [SW-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_EXEC    = 4'd2,
        ST_WBR     = 4'd3,
        ST_WBI     = 4'd4,
        ST_ADDR    = 4'd5,
        ST_LOAD    = 4'd6,
        ST_MDR2C   = 4'd7,
        ST_COPYMDR = 4'd8,
        ST_STORE   = 4'd9,
        ST_BRANCH  = 4'd10,
        ST_BTAKEN  = 4'd11,
        ST_JR      = 4'd12,
        ST_SAVEPC  = 4'd13,
        ST_WBLINK  = 4'd14,
        ST_JALR    = 4'd15
    } state_e;

    localparam logic [OPW-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OPW-1:0] OP_ADDI  = 6'b001011;
    localparam logic [OPW-1:0] OP_SEQI  = 6'b011010;
    localparam logic [OPW-1:0] OP_SGRI  = 6'b011001;
    localparam logic [OPW-1:0] OP_LW    = 6'b100011;
    localparam logic [OPW-1:0] OP_SW    = 6'b101011;
    localparam logic [OPW-1:0] OP_BEQZ  = 6'b000100;
    localparam logic [OPW-1:0] OP_BNEZ  = 6'b000101;
    localparam logic [OPW-1:0] OP_JR    = 6'b010110;
    localparam logic [OPW-1:0] OP_JALR  = 6'b010111;

    localparam logic [FNW-1:0] FN_ADD   = 6'b100011;
    localparam logic [FNW-1:0] FN_SGR   = 6'b101011;
    localparam logic [FNW-1:0] FN_SLLI  = 6'b000000;
    localparam logic [FNW-1:0] FN_SRLI  = 6'b000010;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_EQ  = 3'd1,
        ALU_GT  = 3'd2,
        ALU_SLL = 3'd3,
        ALU_SRL = 3'd4
    } alu_e;

    typedef enum logic {ASEL_A = 1'b0, ASEL_PC = 1'b1} asel_e;

    typedef enum logic [1:0] {
        BSEL_B = 2'd0, BSEL_IMM = 2'd1, BSEL_ZERO = 2'd2, BSEL_ONE = 2'd3
    } bsel_e;

    typedef enum logic [1:0] {
        CSRC_ALU = 2'd0, CSRC_MDR = 2'd1, CSRC_PC = 2'd2
    } csrc_e;

    typedef enum logic {MSRC_MEM = 1'b0, MSRC_B = 1'b1} msrc_e;

    typedef enum logic [1:0] {
        DST_ITYPE = 2'd0, DST_RTYPE = 2'd1, DST_LINK = 2'd2
    } dst_e;

    typedef enum logic [3:0] {
        K_BAD, K_REG, K_IMM, K_LOAD, K_STORE, K_BEQZ, K_BNEZ, K_JR, K_JALR
    } kind_e;

    typedef struct packed {
        kind_e kind;
        alu_e  fn;
    } insn_t;

    typedef struct packed {
        logic    ir_ce;
        logic    pc_ce;
        logic    ab_ce;
        logic    c_ce;
        logic    mar_ce;
        logic    mdr_ce;
        logic    mem_rd;
        logic    mem_wr;
        logic    gpr_we;
        dst_e    dst;
        asel_e   a;
        bsel_e   b;
        alu_e    fn;
        csrc_e   c_src;
        msrc_e   mdr_src;
    } ctrl_t;

    function automatic logic is_shift(alu_e f);
        return (f == ALU_SLL) || (f == ALU_SRL);
    endfunction

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic [FNW-1:0] func,
    output insn_t          insn
);
    always_comb begin
        insn.kind = K_BAD;
        insn.fn   = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                unique case (func)
                    FN_ADD:  begin insn.kind = K_REG; insn.fn = ALU_ADD; end
                    FN_SGR:  begin insn.kind = K_REG; insn.fn = ALU_GT;  end
                    FN_SLLI: begin insn.kind = K_REG; insn.fn = ALU_SLL; end
                    FN_SRLI: begin insn.kind = K_REG; insn.fn = ALU_SRL; end
                    default: insn.kind = K_BAD;
                endcase
            end
            OP_ADDI: begin insn.kind = K_IMM; insn.fn = ALU_ADD; end
            OP_SEQI: begin insn.kind = K_IMM; insn.fn = ALU_EQ;  end
            OP_SGRI: begin insn.kind = K_IMM; insn.fn = ALU_GT;  end
            OP_LW:   insn.kind = K_LOAD;
            OP_SW:   insn.kind = K_STORE;
            OP_BEQZ: insn.kind = K_BEQZ;
            OP_BNEZ: insn.kind = K_BNEZ;
            OP_JR:   insn.kind = K_JR;
            OP_JALR: insn.kind = K_JALR;
            default: insn.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/mcc_next.sv
module mcc_next
    import mcc_pkg::*;
(
    input  state_e cur,
    input  kind_e  kind,
    input  logic   mem_busy,
    input  logic   test_true,
    output state_e nxt
);
    logic taken;
    assign taken = (kind == K_BEQZ) ? test_true : !test_true;

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:   nxt = mem_busy ? ST_FETCH : ST_DECODE;
            ST_DECODE: begin
                unique case (kind)
                    K_REG, K_IMM:     nxt = ST_EXEC;
                    K_LOAD, K_STORE:  nxt = ST_ADDR;
                    K_BEQZ, K_BNEZ:   nxt = ST_BRANCH;
                    K_JR:             nxt = ST_JR;
                    K_JALR:           nxt = ST_SAVEPC;
                    default:          nxt = ST_FETCH;
                endcase
            end
            ST_EXEC:    nxt = (kind == K_IMM) ? ST_WBI : ST_WBR;
            ST_ADDR:    nxt = (kind == K_LOAD) ? ST_LOAD : ST_COPYMDR;
            ST_LOAD:    nxt = mem_busy ? ST_LOAD : ST_MDR2C;
            ST_MDR2C:   nxt = ST_WBI;
            ST_COPYMDR: nxt = ST_STORE;
            ST_STORE:   nxt = mem_busy ? ST_STORE : ST_FETCH;
            ST_BRANCH:  nxt = taken ? ST_BTAKEN : ST_FETCH;
            ST_SAVEPC:  nxt = ST_WBLINK;
            ST_WBLINK:  nxt = ST_JALR;
            default:    nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_outgen.sv
module mcc_outgen
    import mcc_pkg::*;
(
    input  logic   rst,
    input  state_e state,
    input  insn_t  insn,
    input  logic   mem_busy,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        if (!rst) begin
            unique case (state)
                ST_FETCH: begin
                    ctl.mem_rd = 1'b1;
                    ctl.ir_ce  = !mem_busy;
                end
                ST_DECODE: begin
                    ctl.ab_ce = 1'b1;
                    ctl.pc_ce = 1'b1;
                    ctl.a     = ASEL_PC;
                    ctl.b     = BSEL_ONE;
                    ctl.fn    = ALU_ADD;
                end
                ST_EXEC: begin
                    ctl.c_ce  = 1'b1;
                    ctl.c_src = CSRC_ALU;
                    ctl.a     = ASEL_A;
                    ctl.fn    = insn.fn;
                    if (insn.kind == K_IMM)      ctl.b = BSEL_IMM;
                    else if (is_shift(insn.fn))  ctl.b = BSEL_ONE;
                    else                         ctl.b = BSEL_B;
                end
                ST_WBR: begin
                    ctl.gpr_we = 1'b1;
                    ctl.dst    = DST_RTYPE;
                end
                ST_WBI: begin
                    ctl.gpr_we = 1'b1;
                    ctl.dst    = DST_ITYPE;
                end
                ST_ADDR: begin
                    ctl.mar_ce = 1'b1;
                    ctl.a      = ASEL_A;
                    ctl.b      = BSEL_IMM;
                    ctl.fn     = ALU_ADD;
                end
                ST_LOAD: begin
                    ctl.mem_rd  = 1'b1;
                    ctl.mdr_ce  = !mem_busy;
                    ctl.mdr_src = MSRC_MEM;
                end
                ST_MDR2C: begin
                    ctl.c_ce  = 1'b1;
                    ctl.c_src = CSRC_MDR;
                end
                ST_COPYMDR: begin
                    ctl.mdr_ce  = 1'b1;
                    ctl.mdr_src = MSRC_B;
                end
                ST_STORE: ctl.mem_wr = 1'b1;
                ST_BRANCH: begin
                    ctl.a  = ASEL_A;
                    ctl.b  = BSEL_ZERO;
                    ctl.fn = ALU_EQ;
                end
                ST_BTAKEN: begin
                    ctl.pc_ce = 1'b1;
                    ctl.a     = ASEL_PC;
                    ctl.b     = BSEL_IMM;
                    ctl.fn    = ALU_ADD;
                end
                ST_JR, ST_JALR: begin
                    ctl.pc_ce = 1'b1;
                    ctl.a     = ASEL_A;
                    ctl.b     = BSEL_ZERO;
                    ctl.fn    = ALU_ADD;
                end
                ST_SAVEPC: begin
                    ctl.c_ce  = 1'b1;
                    ctl.c_src = CSRC_PC;
                end
                ST_WBLINK: begin
                    ctl.gpr_we = 1'b1;
                    ctl.dst    = DST_LINK;
                end
                default: ctl = '0;
            endcase
        end
    end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPW-1:0]    opcode,
    input  logic [FNW-1:0]    func,
    input  logic              mem_busy,
    input  logic              test_true,
    output logic [NSTATE-1:0] state_oh,
    output logic              ir_ce,
    output logic              pc_ce,
    output logic              ab_ce,
    output logic              c_ce,
    output logic              mar_ce,
    output logic              mdr_ce,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              gpr_we,
    output logic [1:0]        dst_sel,
    output logic              a_sel,
    output logic [1:0]        b_sel,
    output logic [2:0]        alu_fn,
    output logic [1:0]        c_src,
    output logic              mdr_src
);
    state_e state_q, state_d;
    insn_t  insn;
    ctrl_t  ctl;

    mcc_decode u_decode (
        .opcode (opcode),
        .func   (func),
        .insn   (insn)
    );

    mcc_next u_next (
        .cur       (state_q),
        .kind      (insn.kind),
        .mem_busy  (mem_busy),
        .test_true (test_true),
        .nxt       (state_d)
    );

    mcc_outgen u_outgen (
        .rst      (rst),
        .state    (state_q),
        .insn     (insn),
        .mem_busy (mem_busy),
        .ctl      (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    for (genvar i = 0; i < NSTATE; i++) begin : g_onehot
        assign state_oh[i] = (state_q == state_e'(i));
    end

    assign ir_ce   = ctl.ir_ce;
    assign pc_ce   = ctl.pc_ce;
    assign ab_ce   = ctl.ab_ce;
    assign c_ce    = ctl.c_ce;
    assign mar_ce  = ctl.mar_ce;
    assign mdr_ce  = ctl.mdr_ce;
    assign mem_rd  = ctl.mem_rd;
    assign mem_wr  = ctl.mem_wr;
    assign gpr_we  = ctl.gpr_we;
    assign dst_sel = ctl.dst;
    assign a_sel   = ctl.a;
    assign b_sel   = ctl.b;
    assign alu_fn  = ctl.fn;
    assign c_src   = ctl.c_src;
    assign mdr_src = ctl.mdr_src;

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1); // R13
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R13
    AST_WE_IN_WB: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (state_oh[ST_WBI] || state_oh[ST_WBR] || state_oh[ST_WBLINK])); // R13
    AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && mem_busy) |=> state_q == ST_FETCH); // R2
    AST_IR_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        ir_ce |-> (mem_rd && !mem_busy)); // R2
    AST_DECODE_ONCE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DECODE |=> state_q != ST_DECODE); // R3
    AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && mem_busy) |=> state_q == ST_LOAD); // R7
    AST_STORE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STORE && mem_busy) |=> state_q == ST_STORE); // R8
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRANCH && ((insn.kind == K_BEQZ) == test_true))
        |=> state_q == ST_BTAKEN); // R9
    AST_BAD_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && insn.kind == K_BAD) |=> state_q == ST_FETCH); // R12

endmodule

// File: tb/mcc_ctrl_bench.sv
module mcc_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int S_FETCH = 0, S_DECODE = 1, S_EXEC = 2, S_WBR = 3, S_WBI = 4,
                   S_ADDR = 5, S_LOAD = 6, S_MDR2C = 7, S_COPYMDR = 8, S_STORE = 9,
                   S_BRANCH = 10, S_BTAKEN = 11, S_JR = 12, S_SAVEPC = 13,
                   S_WBLINK = 14, S_JALR = 15;
    localparam int K_BAD = 0, K_REG = 1, K_IMM = 2, K_LOAD = 3, K_STORE = 4,
                   K_BEQZ = 5, K_BNEZ = 6, K_JR = 7, K_JALR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] func = '0;
    logic test_true = 1'b0;
    logic mem_busy;
    logic [15:0] state_oh;
    logic ir_ce, pc_ce, ab_ce, c_ce, mar_ce, mdr_ce, mem_rd, mem_wr, gpr_we;
    logic [1:0] dst_sel, b_sel, c_src;
    logic a_sel, mdr_src;
    logic [2:0] alu_fn;

    int checks = 0;
    int failures = 0;
    int lat_v = 0;
    int cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_ctrl u_mcc_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .func(func),
        .mem_busy(mem_busy), .test_true(test_true), .state_oh(state_oh),
        .ir_ce(ir_ce), .pc_ce(pc_ce), .ab_ce(ab_ce), .c_ce(c_ce),
        .mar_ce(mar_ce), .mdr_ce(mdr_ce), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .gpr_we(gpr_we), .dst_sel(dst_sel), .a_sel(a_sel), .b_sel(b_sel),
        .alu_fn(alu_fn), .c_src(c_src), .mdr_src(mdr_src)
    );

    // memory stub: busy for lat_v cycles of a request, done in the next one
    assign mem_busy = (mem_rd || mem_wr) && (cnt < lat_v);
    always_ff @(posedge clk) begin
        if (rst || !mem_busy) cnt <= 0;
        else                  cnt <= cnt + 1;
    end

    function automatic logic [19:0] obs();
        return {ir_ce, pc_ce, ab_ce, c_ce, mar_ce, mdr_ce, mem_rd, mem_wr, gpr_we,
                dst_sel, a_sel, b_sel, alu_fn, c_src, mdr_src};
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void classify(input logic [5:0] op, input logic [5:0] fn,
                                     output int kind, output int af);
        kind = K_BAD; af = 0;
        case (op)
            6'b000000: case (fn)
                6'b100011: begin kind = K_REG; af = 0; end
                6'b101011: begin kind = K_REG; af = 2; end
                6'b000000: begin kind = K_REG; af = 3; end
                6'b000010: begin kind = K_REG; af = 4; end
                default:   kind = K_BAD;
            endcase
            6'b001011: begin kind = K_IMM; af = 0; end
            6'b011010: begin kind = K_IMM; af = 1; end
            6'b011001: begin kind = K_IMM; af = 2; end
            6'b100011: kind = K_LOAD;
            6'b101011: kind = K_STORE;
            6'b000100: kind = K_BEQZ;
            6'b000101: kind = K_BNEZ;
            6'b010110: kind = K_JR;
            6'b010111: kind = K_JALR;
            default:   kind = K_BAD;
        endcase
    endfunction

    function automatic int next_state(int es, int kind, logic busy, logic tt);
        case (es)
            S_FETCH:  return busy ? S_FETCH : S_DECODE;
            S_DECODE: case (kind)
                K_REG, K_IMM:    return S_EXEC;
                K_LOAD, K_STORE: return S_ADDR;
                K_BEQZ, K_BNEZ:  return S_BRANCH;
                K_JR:            return S_JR;
                K_JALR:          return S_SAVEPC;
                default:         return S_FETCH;
            endcase
            S_EXEC:    return (kind == K_IMM) ? S_WBI : S_WBR;
            S_ADDR:    return (kind == K_LOAD) ? S_LOAD : S_COPYMDR;
            S_LOAD:    return busy ? S_LOAD : S_MDR2C;
            S_MDR2C:   return S_WBI;
            S_COPYMDR: return S_STORE;
            S_STORE:   return busy ? S_STORE : S_FETCH;
            S_BRANCH:  return ((kind == K_BEQZ) == tt) ? S_BTAKEN : S_FETCH;
            S_SAVEPC:  return S_WBLINK;
            S_WBLINK:  return S_JALR;
            default:   return S_FETCH;
        endcase
    endfunction

    function automatic string req_of(int es, int kind, int af);
        if (kind == K_BAD) return "R12";
        case (es)
            S_FETCH:  return "R2";
            S_DECODE: return "R3";
            default: ;
        endcase
        case (kind)
            K_REG:   return (af == 0) ? "R4" : (af == 2) ? "R5" : "R6";
            K_IMM:   return (af == 0) ? "R4" : "R5";
            K_LOAD:  return "R7";
            K_STORE: return "R8";
            K_JR:    return "R10";
            K_JALR:  return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic check_cycle(int es, int kind, int af);
        logic ir = 0, pc = 0, ab = 0, cc = 0, mar = 0, mdr = 0, rd = 0, wr = 0, we = 0;
        logic [1:0] dst = 0, b = 0, cs = 0;
        logic a = 0, ms = 0, mux_care = 0;
        logic [2:0] fn = 0;
        logic [19:0] e, m;
        string rq;
        rq = req_of(es, kind, af);
        case (es)
            S_FETCH:   begin rd = 1; ir = !mem_busy; end
            S_DECODE:  begin ab = 1; pc = 1; a = 1; b = 3; fn = 0; end
            S_EXEC:    begin cc = 1; cs = 0; a = 0; fn = 3'(af);
                             b = (kind == K_IMM) ? 2'd1 : (af >= 3) ? 2'd3 : 2'd0; end
            S_WBR:     begin we = 1; dst = 1; end
            S_WBI:     begin we = 1; dst = 0; end
            S_ADDR:    begin mar = 1; a = 0; b = 1; fn = 0; end
            S_LOAD:    begin rd = 1; mdr = !mem_busy; ms = 0; end
            S_MDR2C:   begin cc = 1; cs = 1; end
            S_COPYMDR: begin mdr = 1; ms = 1; end
            S_STORE:   wr = 1;
            S_BRANCH:  begin a = 0; b = 2; fn = 1; mux_care = 1; end
            S_BTAKEN:  begin pc = 1; a = 1; b = 1; fn = 0; end
            S_JR, S_JALR: begin pc = 1; a = 0; b = 2; fn = 0; end
            S_SAVEPC:  begin cc = 1; cs = 2; end
            default:   begin we = 1; dst = 2; end
        endcase
        mux_care = mux_care || pc || mar || (cc && cs == 0);
        e = {ir, pc, ab, cc, mar, mdr, rd, wr, we, dst, a, b, fn, cs, ms};
        m = {9'h1FF, {2{we}}, {6{mux_care}}, {2{cc}}, mdr};
        check({rq, " R13 state"}, {4'd0, state_oh}, {4'd0, 16'(1) << es});
        check({rq, " enables"}, obs() & {9'h1FF, 11'h0}, e & {9'h1FF, 11'h0});
        check({rq, " R14 selects"}, obs() & m & {9'h0, 11'h7FF}, e & m & {9'h0, 11'h7FF});
    endtask

    task automatic run_one(input logic [5:0] op, input logic [5:0] fn,
                           input int lat, input logic tt);
        int kind, af, es, nx;
        classify(op, fn, kind, af);
        opcode = op; func = fn; lat_v = lat; test_true = tt;
        es = S_FETCH;
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            check_cycle(es, kind, af);
            nx = next_state(es, kind, mem_busy, tt);
            @(posedge clk); #1;
            es = nx;
            if (es == S_FETCH) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state and quiet outputs
        repeat (3) begin
            @(negedge clk);
            check("R1 state", {4'd0, state_oh}, 20'h00001);
            check("R1 outputs", obs(), 20'h0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        // sweep every opcode, then every function code of the register group
        for (int op = 0; op < 64; op++)
            for (int l = 0; l <= 2; l += 2)
                for (int t = 0; t < 2; t++)
                    run_one(6'(op), 6'b100011, l, 1'(t));
        for (int fn = 0; fn < 64; fn++)
            for (int l = 0; l <= 2; l += 2)
                for (int t = 0; t < 2; t++)
                    run_one(6'b000000, 6'(fn), l, 1'(t));
        // R1: reset in the middle of a stalled load
        opcode = 6'b100011; lat_v = 3;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (state_oh[S_LOAD]) break;
        end
        check("R7 reached load", {19'd0, state_oh[S_LOAD]}, 20'd1);
        rst = 1'b1;
        #1;
        check("R1 outputs during reset", obs(), 20'h0);
        @(negedge clk);
        check("R1 state after reset", {4'd0, state_oh}, 20'h00001);
        check("R1 outputs after reset", obs(), 20'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        run_one(6'b001011, 6'b0, 1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule